// File: doc/BRIEF.md
# Register-Programmed Block DMA Engine

The engine copies a block of 32-bit words between a local SDRAM port and a PCI memory port. Software loads a source address and a destination address, then writes a control word holding the byte count, the direction of movement and the bus command to use when writing to the PCI side. That control write starts the copy. The engine then alternates one word read on the source side with one word write on the destination side. Each read and each write goes through a simple request/acknowledge port. When the last word has been written, the engine raises a done flag. It can also raise an interrupt.

While a copy runs, the address and length registers serve as the live counters. Their contents are therefore not meaningful during or after a copy. Software follows progress only through the busy and done flags. A start request with bad settings is refused and sets an error flag, and so is a start request made while a copy is already running.

Top module: `dma_block_engine`

## Requirements
- R1: Register offsets on `reg_addr` are 0 source address, 1 destination address, 2 control and 3 status. An accepted control write sets busy (status bit 0) at the same clock edge. The first source-side request appears in the cycle after that edge.
- R2: The control word fields are: length in bytes in bits 25:0, direction in bit 26 and write type in bit 27. With direction 0 the engine reads SDRAM at the source address (`mem_we`=0). It then writes the word to PCI at the destination address with `pci_cmd` 4'b0111 when the write type is 0, or 4'b1111 when it is 1.
- R3: With direction 1 the engine reads PCI at the source address with `pci_cmd` 4'b0110. It then writes the word to SDRAM at the destination address (`mem_we`=1).
- R4: A copy makes exactly length/4 read/write pairs. Both addresses step up by 4 after each pair, so destination word k receives source word k.
- R5: At the edge where the last write is acknowledged, busy clears and done (status bit 1) sets.
- R6: Writing status with bit 1 set clears done, and writing status with bit 2 set clears error. Every status write loads the interrupt enable from bit 8. Hardware setting takes priority over a clear made in the same cycle.
- R7: A control write is refused in these cases: the source or destination address has bit 1 or bit 0 set, or the length is zero, or the length is not a multiple of 4. A refused write sets error (status bit 2), leaves busy at 0 and issues no request on either port.
- R8: A control write while busy is refused and sets error. The running copy continues unchanged with its original length.
- R9: `irq` is high exactly while done is set and the interrupt enable is 1.
- R10: At most one of `mem_req` and `pci_req` is high at a time. A request stays high, with its address steady, until its acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | SDRAM-side request |
| mem_we | output | 1 | SDRAM-side request is a write |
| mem_addr | output | 32 | SDRAM-side byte address |
| mem_wdata | output | 32 | SDRAM-side write data |
| mem_ack | input | 1 | SDRAM-side completion pulse |
| mem_rdata | input | 32 | SDRAM-side read data, valid with `mem_ack` |
| pci_req | output | 1 | PCI-side request |
| pci_cmd | output | 4 | PCI-side bus command |
| pci_addr | output | 32 | PCI-side byte address |
| pci_wdata | output | 32 | PCI-side write data |
| pci_ack | input | 1 | PCI-side completion pulse |
| pci_rdata | input | 32 | PCI-side read data, valid with `pci_ack` |
| irq | output | 1 | Interrupt request |

## Verification
Several internal faults show at the ports. If the engine loses track of busy, a stray request appears, or busy stays set after the final acknowledge. If a length counter is wrong, the copy makes one pair too many or too few, and this shows as soon as the copy ends as a wrong write count or a stale destination word. If an address step is wrong, a wrong word lands at the destination, so each copied word is compared with the source word it should hold. A bad command encoding shows on the first request of that kind, and a broken refusal shows one cycle after the control write as busy, or as a request.

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam int WORD_W = 32;
   localparam int OFF_W  = 2;

   localparam logic [OFF_W-1:0] OFF_SRC  = 2'd0;
   localparam logic [OFF_W-1:0] OFF_DST  = 2'd1;
   localparam logic [OFF_W-1:0] OFF_CTL  = 2'd2;
   localparam logic [OFF_W-1:0] OFF_STAT = 2'd3;

   localparam int STAT_BUSY = 0;
   localparam int STAT_DONE = 1;
   localparam int STAT_ERR  = 2;
   localparam int STAT_IE   = 8;

   localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
   localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [OFF_W-1:0]  reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              step_i,
   input  logic              last_i,
   output logic              start_o,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              dir_o,
   output logic              wai_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              ie_o
);
   localparam int DIR_BIT = LEN_W;
   localparam int WAI_BIT = LEN_W + 1;
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(4);
   localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(4);

   logic [ADDR_W-1:0] src_q, dst_q;
   logic [LEN_W-1:0]  len_q;
   logic              dir_q, wai_q, busy_q, done_q, err_q, ie_q;

   logic wr_src, wr_dst, wr_ctl, wr_stat;
   logic [LEN_W-1:0] new_len;
   logic ctl_ok, start, reject;

   assign wr_src  = reg_we && (reg_addr == OFF_SRC);
   assign wr_dst  = reg_we && (reg_addr == OFF_DST);
   assign wr_ctl  = reg_we && (reg_addr == OFF_CTL);
   assign wr_stat = reg_we && (reg_addr == OFF_STAT);

   assign new_len = reg_wdata[LEN_W-1:0];
   assign ctl_ok  = (src_q[1:0] == 2'b00) && (dst_q[1:0] == 2'b00) &&
                    (new_len != '0) && (new_len[1:0] == 2'b00);
   assign start   = wr_ctl && ctl_ok && !busy_q;
   assign reject  = wr_ctl && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
      end else if (step_i) begin
         src_q <= src_q + ADDR_STEP;
         dst_q <= dst_q + ADDR_STEP;
      end else if (!busy_q) begin
         if (wr_src) src_q <= reg_wdata[ADDR_W-1:0];
         if (wr_dst) dst_q <= reg_wdata[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         dir_q <= 1'b0;
         wai_q <= 1'b0;
      end else if (start) begin
         len_q <= new_len;
         dir_q <= reg_wdata[DIR_BIT];
         wai_q <= reg_wdata[WAI_BIT];
      end else if (step_i) begin
         len_q <= len_q - LEN_STEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         if (start)       busy_q <= 1'b1;
         else if (last_i) busy_q <= 1'b0;

         if (last_i)                             done_q <= 1'b1;
         else if (wr_stat && reg_wdata[STAT_DONE]) done_q <= 1'b0;

         if (reject)                             err_q <= 1'b1;
         else if (wr_stat && reg_wdata[STAT_ERR]) err_q <= 1'b0;

         if (wr_stat) ie_q <= reg_wdata[STAT_IE];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFF_SRC: reg_rdata[ADDR_W-1:0] = src_q;
         OFF_DST: reg_rdata[ADDR_W-1:0] = dst_q;
         OFF_CTL: begin
            reg_rdata[LEN_W-1:0] = len_q;
            reg_rdata[DIR_BIT]   = dir_q;
            reg_rdata[WAI_BIT]   = wai_q;
         end
         default: begin
            reg_rdata[STAT_BUSY] = busy_q;
            reg_rdata[STAT_DONE] = done_q;
            reg_rdata[STAT_ERR]  = err_q;
            reg_rdata[STAT_IE]   = ie_q;
         end
      endcase
   end

   assign start_o = start;
   assign src_o   = src_q;
   assign dst_o   = dst_q;
   assign len_o   = len_q;
   assign dir_o   = dir_q;
   assign wai_o   = wai_q;
   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign ie_o    = ie_q;

   // R5: last acknowledged write ends the copy and flags completion
   assert_finish_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last_i |=> (done_q && !busy_q));

   // R7: a refused start while idle leaves the engine idle and flags error
   assert_reject_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && !busy_q) |=> (!busy_q && err_q));

   // R8: a control write during a copy cannot restart or reload the length
   assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && busy_q && !step_i) |=> $stable(len_q));
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
   import dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_i,
   input  logic              wai_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              pci_req,
   output logic [3:0]        pci_cmd,
   output logic [ADDR_W-1:0] pci_addr,
   output logic [WORD_W-1:0] pci_wdata,
   input  logic              pci_ack,
   input  logic [WORD_W-1:0] pci_rdata,
   output logic              step_o,
   output logic              last_o,
   output logic              active_o
);
   localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(4);

   dma_state_e        state_q, state_d;
   logic [WORD_W-1:0] buf_q;
   logic              in_rd, in_wr, rd_ack, wr_ack;
   logic [ADDR_W-1:0] cur_addr;

   assign in_rd    = (state_q == ST_RD);
   assign in_wr    = (state_q == ST_WR);
   assign cur_addr = in_rd ? src_i : dst_i;

   // direction 0: read on SDRAM side, write on PCI side; direction 1 the reverse
   assign rd_ack = dir_i ? pci_ack : mem_ack;
   assign wr_ack = dir_i ? mem_ack : pci_ack;

   assign mem_req   = (in_rd && !dir_i) || (in_wr && dir_i);
   assign mem_we    = in_wr;
   assign mem_addr  = cur_addr;
   assign mem_wdata = buf_q;

   assign pci_req   = (in_rd && dir_i) || (in_wr && !dir_i);
   assign pci_cmd   = in_rd ? CMD_MEM_RD : (wai_i ? CMD_MEM_WRI : CMD_MEM_WR);
   assign pci_addr  = cur_addr;
   assign pci_wdata = buf_q;

   assign step_o   = in_wr && wr_ack;
   assign last_o   = step_o && (len_i == ONE_WORD);
   assign active_o = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i) state_d = ST_RD;
         ST_RD:   if (rd_ack)  state_d = ST_WR;
         ST_WR:   if (wr_ack)  state_d = (len_i == ONE_WORD) ? ST_IDLE : ST_RD;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         buf_q   <= '0;
      end else begin
         state_q <= state_d;
         if (in_rd && rd_ack) buf_q <= dir_i ? pci_rdata : mem_rdata;
      end
   end

   // R10: only one port is asked at a time
   assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, pci_req}));

   // R10: an unanswered SDRAM request holds with a steady address
   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10: an unanswered PCI request holds with a steady address
   assert_pci_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_req && !pci_ack) |=> (pci_req && $stable(pci_addr) && $stable(pci_cmd)));
endmodule

// File: rtl/dma_block_engine.sv
module dma_block_engine
   import dma_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 26,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [OFF_W-1:0]  reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              pci_req,
   output logic [3:0]        pci_cmd,
   output logic [ADDR_W-1:0] pci_addr,
   output logic [WORD_W-1:0] pci_wdata,
   input  logic              pci_ack,
   input  logic [WORD_W-1:0] pci_rdata,
   output logic              irq
);
   initial begin
      assert (ADDR_W >= 3 && ADDR_W <= WORD_W)
         else $error("ADDR_W must lie between 3 and the word width");
      assert (LEN_W >= 3 && LEN_W + 2 <= WORD_W)
         else $error("LEN_W plus two control bits must fit one word");
   end

   logic              start, step, last, busy, done, ie, active, dir, wai;
   logic [ADDR_W-1:0] src, dst;
   logic [LEN_W-1:0]  len;

   dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .step_i    (step),
      .last_i    (last),
      .start_o   (start),
      .src_o     (src),
      .dst_o     (dst),
      .len_o     (len),
      .dir_o     (dir),
      .wai_o     (wai),
      .busy_o    (busy),
      .done_o    (done),
      .ie_o      (ie)
   );

   dma_xfer_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .dir_i     (dir),
      .wai_i     (wai),
      .src_i     (src),
      .dst_i     (dst),
      .len_i     (len),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .pci_req   (pci_req),
      .pci_cmd   (pci_cmd),
      .pci_addr  (pci_addr),
      .pci_wdata (pci_wdata),
      .pci_ack   (pci_ack),
      .pci_rdata (pci_rdata),
      .step_o    (step),
      .last_o    (last),
      .active_o  (active)
   );

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done && ie;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = done && ie;
      end
   endgenerate

   // R1: the status busy flag and the sequencer agree in every cycle
   assert_busy_tracks_engine_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy == active);

   // R9: the interrupt never rises without the enable set
   assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ie);
endmodule

// File: tb/tb_dma_block_engine.sv
`timescale 1ns/1ps
module tb_dma_block_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        pci_req, pci_ack;
   logic [3:0]  pci_cmd;
   logic [31:0] pci_addr, pci_wdata, pci_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dma_block_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .pci_req(pci_req), .pci_cmd(pci_cmd), .pci_addr(pci_addr),
      .pci_wdata(pci_wdata), .pci_ack(pci_ack), .pci_rdata(pci_rdata),
      .irq(irq)
   );

   // ---------------- port models ----------------
   logic [31:0] sdram_m [0:255];
   logic [31:0] pci_m   [0:255];
   int mem_lat = 0, pci_lat = 0, mem_cnt = 0, pci_cnt = 0;
   int mem_rd_n = 0, mem_wr_n = 0, pci_rd_n = 0, pci_wr_n = 0, bad_cmd_n = 0;
   logic [3:0] last_wcmd = 4'h0;

   initial begin
      mem_ack = 1'b0; pci_ack = 1'b0; mem_rdata = '0; pci_rdata = '0;
      for (int i = 0; i < 256; i++) begin
         sdram_m[i] = 32'h5D00_0000 | i;
         pci_m[i]   = 32'hC700_0000 | i;
      end
   end

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (mem_cnt >= mem_lat) begin
            mem_cnt <= 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               sdram_m[mem_addr[9:2]] <= mem_wdata;
               mem_wr_n <= mem_wr_n + 1;
            end else begin
               mem_rdata <= sdram_m[mem_addr[9:2]];
               mem_rd_n <= mem_rd_n + 1;
            end
         end else mem_cnt <= mem_cnt + 1;
      end
   end

   always @(posedge clk) begin
      pci_ack <= 1'b0;
      if (pci_req && !pci_ack) begin
         if (pci_cnt >= pci_lat) begin
            pci_cnt <= 0;
            pci_ack <= 1'b1;
            if (pci_cmd == 4'b0110) begin
               pci_rdata <= pci_m[pci_addr[9:2]];
               pci_rd_n <= pci_rd_n + 1;
            end else if (pci_cmd == 4'b0111 || pci_cmd == 4'b1111) begin
               pci_m[pci_addr[9:2]] <= pci_wdata;
               pci_wr_n <= pci_wr_n + 1;
               last_wcmd <= pci_cmd;
            end else bad_cmd_n <= bad_cmd_n + 1;
         end else pci_cnt <= pci_cnt + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input bit ok, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd_reg(2'd3, s);
         if (!s[0]) break;
      end
   endtask

   function automatic logic [31:0] ctl(input int len, input bit dir, input bit wai);
      return (32'(len) & 32'h03FF_FFFF) | (32'(dir) << 26) | (32'(wai) << 27);
   endfunction

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [31:0] s;
      rd_reg(2'd3, s);
      check(s == 32'h0, "R1 status after reset", s, 32'h0);
      check(!irq && !mem_req && !pci_req, "R10 idle ports after reset",
            {29'd0, irq, mem_req, pci_req}, 32'h0);
   endtask

   task automatic t_start_timing();
      logic [31:0] s;
      wr_reg(2'd0, 32'h0000_0010);
      wr_reg(2'd1, 32'h0000_0200);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = ctl(4, 1'b0, 1'b0);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd3;
      #1 s = reg_rdata;
      check(s[0] == 1'b1, "R1 busy after control write", s, 32'h1);
      check(mem_req && !mem_we && mem_addr == 32'h10, "R1 first read request",
            mem_addr, 32'h10);
      wait_idle();
      check(pci_m[128] == sdram_m[4], "R4 single word copy", pci_m[128], sdram_m[4]);
      wr_reg(2'd3, 32'h0000_0006);
   endtask

   task automatic t_dma_write(input bit wai, input int src, input int dst, input int len);
      logic [31:0] exp [0:63];
      logic [31:0] s;
      int n = len / 4;
      int w0 = pci_wr_n;
      for (int k = 0; k < n; k++) exp[k] = sdram_m[src/4 + k];
      wr_reg(2'd3, 32'h0000_0106);
      wr_reg(2'd0, 32'(src));
      wr_reg(2'd1, 32'(dst));
      wr_reg(2'd2, ctl(len, 1'b0, wai));
      wait_idle();
      for (int k = 0; k < n; k++)
         check(pci_m[dst/4 + k] == exp[k], "R4 R2 destination word", pci_m[dst/4 + k], exp[k]);
      check(pci_wr_n - w0 == n, "R4 write count", 32'(pci_wr_n - w0), 32'(n));
      check(last_wcmd == (wai ? 4'b1111 : 4'b0111), "R2 write command",
            {28'd0, last_wcmd}, wai ? 32'hF : 32'h7);
      check(bad_cmd_n == 0, "R2 no bad command", 32'(bad_cmd_n), 32'h0);
      rd_reg(2'd3, s);
      check(s[1:0] == 2'b10, "R5 done set busy clear", s, 32'h102);
      check(irq == 1'b1, "R9 irq with enable and done", {31'd0, irq}, 32'h1);
   endtask

   task automatic t_dma_read();
      logic [31:0] exp [0:7];
      logic [31:0] s;
      int r0 = pci_rd_n, w0 = mem_wr_n;
      for (int k = 0; k < 8; k++) exp[k] = pci_m[8 + k];
      wr_reg(2'd3, 32'h0000_0106);
      wr_reg(2'd0, 32'h0000_0020);
      wr_reg(2'd1, 32'h0000_0300);
      wr_reg(2'd2, ctl(32, 1'b1, 1'b1));
      wait_idle();
      for (int k = 0; k < 8; k++)
         check(sdram_m[192 + k] == exp[k], "R3 R4 SDRAM word", sdram_m[192 + k], exp[k]);
      check(pci_rd_n - r0 == 8, "R3 read command count", 32'(pci_rd_n - r0), 32'h8);
      check(mem_wr_n - w0 == 8, "R3 SDRAM write count", 32'(mem_wr_n - w0), 32'h8);
      rd_reg(2'd3, s);
      check(s[1:0] == 2'b10, "R5 done after read", s, 32'h2);
   endtask

   task automatic t_reject(input int src, input int dst, input int len, input string why);
      logic [31:0] s;
      int tot = mem_rd_n + mem_wr_n + pci_rd_n + pci_wr_n;
      bit seen = 1'b0;
      wr_reg(2'd3, 32'h0000_0006);
      wr_reg(2'd0, 32'(src));
      wr_reg(2'd1, 32'(dst));
      wr_reg(2'd2, ctl(len, 1'b0, 1'b0));
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (mem_req || pci_req) seen = 1'b1;
      end
      rd_reg(2'd3, s);
      check(s[2] == 1'b1 && s[0] == 1'b0, {"R7 refused ", why}, s, 32'h4);
      check(!seen && (mem_rd_n + mem_wr_n + pci_rd_n + pci_wr_n) == tot,
            {"R7 no request ", why}, {31'd0, seen}, 32'h0);
      wr_reg(2'd3, 32'h0000_0004);
      rd_reg(2'd3, s);
      check(s[2] == 1'b0, "R6 error cleared by write one", s, 32'h0);
   endtask

   task automatic t_busy_write();
      logic [31:0] s;
      int w0 = pci_wr_n;
      mem_lat = 3; pci_lat = 2;
      wr_reg(2'd3, 32'h0000_0006);
      wr_reg(2'd0, 32'h0000_0080);
      wr_reg(2'd1, 32'h0000_0180);
      wr_reg(2'd2, ctl(32, 1'b0, 1'b1));
      wr_reg(2'd2, ctl(8, 1'b0, 1'b0));
      rd_reg(2'd3, s);
      check(s[2] == 1'b1 && s[0] == 1'b1, "R8 error while busy", s, 32'h5);
      wait_idle();
      check(pci_wr_n - w0 == 8, "R8 original length kept", 32'(pci_wr_n - w0), 32'h8);
      check(last_wcmd == 4'b1111, "R8 original type kept", {28'd0, last_wcmd}, 32'hF);
      mem_lat = 0; pci_lat = 0;
      wr_reg(2'd3, 32'h0000_0006);
   endtask

   task automatic t_irq_w1c();
      logic [31:0] s;
      t_dma_write(1'b0, 32'h0000_0000, 32'h0000_0040, 8);
      wr_reg(2'd3, 32'h0000_0000);
      rd_reg(2'd3, s);
      check(s[1] == 1'b1 && !irq, "R9 irq low with enable off", s, 32'h2);
      wr_reg(2'd3, 32'h0000_0102);
      rd_reg(2'd3, s);
      check(s[1] == 1'b0 && s[8] && !irq, "R6 done cleared, irq low", s, 32'h100);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_start_timing();
      t_dma_write(1'b0, 32'h0000_0040, 32'h0000_0100, 16);
      t_dma_write(1'b1, 32'h0000_0050, 32'h0000_0280, 24);
      t_dma_read();
      t_reject(32'h41, 32'h100, 8, "misaligned source");
      t_reject(32'h40, 32'h102, 8, "misaligned destination");
      t_reject(32'h40, 32'h100, 0, "zero length");
      t_reject(32'h40, 32'h100, 6, "odd length");
      t_busy_write();
      t_irq_w1c();
      report();
   end
endmodule